// File: doc/BRIEF.md
# Frame-Synchronous UART Line Tunneler

This block carries slow asynchronous serial lines, typically the transmit and receive wires of a console port, across a framed link. On the sending side it passes each local line through a two-flop synchronizer. It then takes three samples of the line in every link frame, at cycle offsets 0, 4 and 8 after the frame-start strobe. The three samples are packed into a per-line field, which is handed to the framer once the frame is complete.

On the receiving side the block takes a per-line sample field from the deframer at frame start. It then replays the samples onto the regenerated output line at the same intra-frame offsets, so the far-end waveform is rebuilt at three times the frame rate. The bits are not decoded as characters. A frame-valid flag qualifies each received field. An invalid frame leaves the outputs frozen. Before the first valid frame the outputs idle at the mark level.

Top module: `uart_frame_tunnel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `line_o` bit is 1 and `tx_field_o` is all zeros.
- R2: Every local line is sampled three times per frame. The samples are taken at the clock edges of cycle offsets 0, 4 and 8, where offset 0 is the cycle in which `frame_start_i` is high.
- R3: The field of line L occupies bits [3L+2:3L] of `tx_field_o` and `rx_field_i`. The sample taken at offset 4k sits in bit 3L+k, so the oldest sample is in the lowest bit.
- R4: The samples of one frame appear on `tx_field_o` in the cycle after the next frame-start strobe. `tx_field_o` changes only in the cycle after a strobe.
- R5: Each line is sampled, packed and replayed independently of the other lines.
- R6: When a strobe arrives with `rx_valid_i` high, bit k of each line's received field is driven onto `line_o` from the cycle after offset 4k. It is held there until the next replay point.
- R7: When `rx_valid_i` is low at a strobe, `line_o` holds its last level for the whole of that frame.
- R8: Before the first strobe, nothing is sampled or replayed. `line_o` stays high and `tx_field_o` stays zero, whatever the line and field inputs do.
- R9: A change on a local line reaches the sampler through two synchronizer flops. A change captured at the edge ending offset 3 therefore misses the offset-4 sample, while one captured at the edge ending offset 2 is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle strobe marking offset 0 of a link frame |
| line_i | input | LINES | Local asynchronous serial lines to be sampled |
| rx_valid_i | input | 1 | Received field is valid, sampled with the strobe |
| rx_field_i | input | LINES*SAMPLES | Sample fields from the deframer |
| tx_field_o | output | LINES*SAMPLES | Packed sample fields toward the framer |
| line_o | output | LINES | Regenerated serial lines |

## Verification
At a frame-start strobe, three things happen in one clock edge. The previous frame's samples are published. The first sample of the new frame is captured. The newly received field is latched and its first bit replayed. The bench sends back-to-back frames whose line patterns and received fields differ from one frame to the next. Each published field is then compared with the previous frame's pattern, and not with the one being captured. Each `line_o` level at offset 2 is compared with bit 0 of the field presented in that same strobe cycle.

// File: rtl/uft_pkg.sv
package uft_pkg;

    // Width of an index able to address n slots (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter able to hold 0..n.
    function automatic int unsigned cnt_width(int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/uft_phase.sv
module uft_phase #(
    parameter int unsigned FRAME_LEN = 12,
    parameter int unsigned SAMPLES   = 3,
    parameter int unsigned SPACING   = 4,
    localparam int unsigned CNT_W    = uft_pkg::cnt_width(FRAME_LEN),
    localparam int unsigned IDX_W    = uft_pkg::idx_width(SAMPLES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             frame_start_i,
    output logic             tick_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] STEP     = CNT_W'(SPACING);
    localparam logic [CNT_W-1:0] SPAN     = CNT_W'(SPACING * SAMPLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } phase_t;

    phase_t phase_d, phase_q;
    logic [CNT_W-1:0] off;
    logic             live;

    always_comb begin
        phase_d = phase_q;
        off     = frame_start_i ? '0 : phase_q.cnt;
        // Counter parks at LAST_OFF: no slots until the next strobe.
        live    = frame_start_i || (phase_q.cnt < LAST_OFF);
        tick_o  = live && ((off % STEP) == '0) && (off < SPAN);
        idx_o   = IDX_W'(off / STEP);
        if (frame_start_i) begin
            phase_d.cnt = CNT_W'(1);
        end else if (phase_q.cnt < LAST_OFF) begin
            phase_d.cnt = phase_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q.cnt <= LAST_OFF;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/uft_sampler.sv
module uft_sampler #(
    parameter int unsigned SAMPLES = 3,
    localparam int unsigned IDX_W  = uft_pkg::idx_width(SAMPLES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               frame_start_i,
    input  logic               tick_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               line_i,
    output logic [SAMPLES-1:0] field_o
);

    typedef struct packed {
        logic               s1;
        logic               s2;
        logic [SAMPLES-1:0] acc;
        logic [SAMPLES-1:0] field;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d    = samp_q;
        samp_d.s1 = line_i;
        samp_d.s2 = samp_q.s1;
        // Publish the finished frame before slot 0 of the new one lands.
        if (frame_start_i) begin
            samp_d.field = samp_q.acc;
        end
        if (tick_i) begin
            samp_d.acc[idx_i] = samp_q.s2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            samp_q.s1    <= 1'b1;
            samp_q.s2    <= 1'b1;
            samp_q.acc   <= '0;
            samp_q.field <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign field_o = samp_q.field;

endmodule

// File: rtl/uft_replay.sv
module uft_replay #(
    parameter int unsigned SAMPLES = 3,
    localparam int unsigned IDX_W  = uft_pkg::idx_width(SAMPLES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               frame_start_i,
    input  logic               tick_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               valid_i,
    input  logic [SAMPLES-1:0] field_i,
    output logic               line_o
);

    typedef struct packed {
        logic               act;
        logic               line;
        logic [SAMPLES-1:0] hold;
    } rep_t;

    rep_t               rep_d, rep_q;
    logic [SAMPLES-1:0] src;
    logic               en;

    always_comb begin
        rep_d = rep_q;
        src   = frame_start_i ? field_i : rep_q.hold;
        en    = frame_start_i ? valid_i : rep_q.act;
        if (frame_start_i) begin
            rep_d.act = valid_i;
            if (valid_i) begin
                rep_d.hold = field_i;
            end
        end
        if (tick_i && en) begin
            rep_d.line = src[idx_i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rep_q.act  <= 1'b0;
            rep_q.line <= 1'b1;
            rep_q.hold <= '1;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign line_o = rep_q.line;

endmodule

// File: rtl/uart_frame_tunnel.sv
module uart_frame_tunnel #(
    parameter int unsigned LINES     = 2,
    parameter int unsigned FRAME_LEN = 12,
    parameter int unsigned SAMPLES   = 3,
    parameter int unsigned SPACING   = 4,
    localparam int unsigned FIELD_W  = LINES * SAMPLES,
    localparam int unsigned IDX_W    = uft_pkg::idx_width(SAMPLES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               frame_start_i,
    input  logic [LINES-1:0]   line_i,
    input  logic               rx_valid_i,
    input  logic [FIELD_W-1:0] rx_field_i,
    output logic [FIELD_W-1:0] tx_field_o,
    output logic [LINES-1:0]   line_o
);

    logic             tick;
    logic [IDX_W-1:0] idx;

    uft_phase #(
        .FRAME_LEN (FRAME_LEN),
        .SAMPLES   (SAMPLES),
        .SPACING   (SPACING)
    ) u_phase (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .frame_start_i (frame_start_i),
        .tick_o        (tick),
        .idx_o         (idx)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_line
        uft_sampler #(
            .SAMPLES (SAMPLES)
        ) u_samp (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .frame_start_i (frame_start_i),
            .tick_i        (tick),
            .idx_i         (idx),
            .line_i        (line_i[l]),
            .field_o       (tx_field_o[l*SAMPLES +: SAMPLES])
        );

        uft_replay #(
            .SAMPLES (SAMPLES)
        ) u_rep (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .frame_start_i (frame_start_i),
            .tick_i        (tick),
            .idx_i         (idx),
            .valid_i       (rx_valid_i),
            .field_i       (rx_field_i[l*SAMPLES +: SAMPLES]),
            .line_o        (line_o[l])
        );
    end

endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
    parameter int unsigned LINES     = 2,
    parameter int unsigned FRAME_LEN = 12,
    parameter int unsigned SAMPLES   = 3,
    parameter int unsigned SPACING   = 4,
    localparam int unsigned FIELD_W  = LINES * SAMPLES,
    localparam int unsigned CNT_W    = uft_pkg::cnt_width(FRAME_LEN)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               frame_start_i,
    input logic               rx_valid_i,
    input logic [FIELD_W-1:0] tx_field_o,
    input logic [LINES-1:0]   line_o
);

    logic [CNT_W-1:0] off_q;
    logic [CNT_W-1:0] cur_off;
    logic             slot_q;
    logic             frozen_q;

    assign cur_off = frame_start_i ? '0 : off_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            off_q    <= CNT_W'(FRAME_LEN);
            slot_q   <= 1'b0;
            frozen_q <= 1'b1;
        end else begin
            slot_q <= (frame_start_i || off_q < CNT_W'(FRAME_LEN))
                      && (int'(cur_off) % SPACING == 0)
                      && (int'(cur_off) < SPACING * SAMPLES);
            if (frame_start_i) begin
                off_q    <= CNT_W'(1);
                frozen_q <= !rx_valid_i;
            end else if (off_q < CNT_W'(FRAME_LEN)) begin
                off_q <= off_q + CNT_W'(1);
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (line_o == '1 && tx_field_o == '0));

    // R4
    field_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tx_field_o) |-> $past(frame_start_i));

    // R6
    line_on_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(line_o) |-> slot_q);

    // R7
    frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frozen_q |-> $stable(line_o));

endmodule

bind uart_frame_tunnel uft_checker #(
    .LINES     (LINES),
    .FRAME_LEN (FRAME_LEN),
    .SAMPLES   (SAMPLES),
    .SPACING   (SPACING)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .rx_valid_i    (rx_valid_i),
    .tx_field_o    (tx_field_o),
    .line_o        (line_o)
);

// File: tb/uart_frame_tunnel_bench.sv
module uart_frame_tunnel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       frame_start_i = 1'b0;
    logic [1:0] line_i = 2'b11;
    logic       rx_valid_i = 1'b0;
    logic [5:0] rx_field_i = '0;
    logic [5:0] tx_field_o;
    logic [1:0] line_o;

    int checks = 0;
    int failures = 0;

    logic [5:0] exp_field = '0;
    logic [1:0] exp_line  = 2'b11;

    // Per frame: local line pattern, received field, frame-valid flag.
    localparam logic [5:0] TXV [NVEC] = '{6'b101_010, 6'b000_111, 6'b111_000, 6'b011_110,
                                          6'b110_001, 6'b010_101, 6'b111_111, 6'b000_000};
    localparam logic [5:0] RXV [NVEC] = '{6'b010_101, 6'b110_011, 6'b001_100, 6'b111_111,
                                          6'b000_000, 6'b100_010, 6'b011_001, 6'b101_110};
    localparam logic       VLD [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    uart_frame_tunnel u_uart_frame_tunnel (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .frame_start_i (frame_start_i),
        .line_i        (line_i),
        .rx_valid_i    (rx_valid_i),
        .rx_field_i    (rx_field_i),
        .tx_field_o    (tx_field_o),
        .line_o        (line_o)
    );

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One frame of FRAME_LEN cycles; nxt supplies slot 0 of the following frame.
    task automatic run_frame(input logic [5:0] tx, input logic [5:0] nxt,
                             input logic [5:0] rx, input logic vld);
        for (int off = 0; off < 12; off++) begin
            @(negedge clk_i);
            frame_start_i = (off == 0);
            if (off == 0) begin
                rx_field_i = rx;
                rx_valid_i = vld;
                // R6 R7: previous level held up to the strobe edge
                check("R6 hold to strobe", {6'b0, line_o}, {6'b0, exp_line});
            end
            if (off == 2) begin
                // R2 R3 R4 R5: previous frame's samples published
                check("R2 R3 R4 R5 field", {2'b0, tx_field_o}, {2'b0, exp_field});
            end
            if (off == 2 || off == 6 || off == 10) begin
                for (int l = 0; l < 2; l++) begin
                    if (vld) exp_line[l] = rx[l*3 + off/4];
                end
                check(vld ? "R6 R5 replay" : "R7 frozen", {6'b0, line_o}, {6'b0, exp_line});
            end
            if (off == 4 || off == 8) begin
                check(vld ? "R6 held slot" : "R7 frozen", {6'b0, line_o}, {6'b0, exp_line});
            end
            for (int l = 0; l < 2; l++) begin
                if (off == 1) line_i[l] = tx[l*3 + 1];
                if (off == 5) line_i[l] = tx[l*3 + 2];
                if (off == 9) line_i[l] = nxt[l*3];
            end
        end
        exp_field = tx;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk_i);
        check("R1 reset line", {6'b0, line_o}, 8'h03);
        check("R1 reset field", {2'b0, tx_field_o}, 8'h00);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 after release", {2'b0, tx_field_o, line_o}, 8'h03);

        // R8: activity without any strobe changes nothing
        rx_valid_i = 1'b1;
        rx_field_i = 6'b000_000;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk_i);
            line_i = 2'(c);
        end
        check("R8 no strobe line", {6'b0, line_o}, 8'h03);
        check("R8 no strobe field", {2'b0, tx_field_o}, 8'h00);

        // Table walk
        for (int l = 0; l < 2; l++) line_i[l] = TXV[0][l*3];
        @(negedge clk_i);
        @(negedge clk_i);
        for (int i = 0; i < NVEC; i++) begin
            run_frame(TXV[i], (i + 1 < NVEC) ? TXV[i+1] : 6'b0, RXV[i], VLD[i]);
        end

        // R9 R5: synchronizer latency, lane 0 changes at offset 2, lane 1 at offset 3
        @(negedge clk_i);
        frame_start_i = 1'b0;
        line_i = 2'b00;
        repeat (3) @(negedge clk_i);
        for (int off = 0; off < 12; off++) begin
            frame_start_i = (off == 0);
            rx_valid_i = 1'b0;
            if (off == 2) line_i[0] = 1'b1;
            if (off == 3) line_i[1] = 1'b1;
            @(negedge clk_i);
        end
        frame_start_i = 1'b1;
        @(negedge clk_i);
        frame_start_i = 1'b0;
        @(negedge clk_i);
        check("R9 R5 sync latency field", {2'b0, tx_field_o}, {2'b0, 6'b100_110});
        check("R7 invalid frames hold line", {6'b0, line_o}, {6'b0, exp_line});

        // R1: reset re-applied mid-run
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1 re-reset", {2'b0, tx_field_o, line_o}, 8'h03);
        rst_ni = 1'b1;
        @(negedge clk_i);

        summary();
    end

endmodule